// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block keeps wall-clock time and a calendar date in a small bank of byte registers that software reaches through a plain address/data port. The fields are seconds, minutes, hours, weekday, day of month, month and a two-digit year. Two control registers sit alongside them: a general-purpose control byte, and a mode byte that chooses the field encoding and can freeze the calendar.

A one-cycle pulse on `tick_sec` marks each elapsed second. On that pulse the calendar moves forward by one second. Carries ripple through minutes, hours, day, weekday, month and year. The day carry respects each month's length, and February follows the leap rule of the two-digit year. Every field is held either as packed BCD (tens digit in the upper nibble, units digit in the lower nibble) or as plain binary. The current value of the mode bit selects which one. Software loads a date by writing the field bytes directly, and a write always wins over a tick that arrives in the same cycle for the byte it addresses.

Top module: `rtc_calendar_regs`

## Requirements
- R1: After reset the fields read 00:00:00 with weekday 7, day 1, month 1 and year 00. The control byte reads 0x26 and the mode byte reads 0x02. In the mode byte, bit 7 is the freeze bit, bit 2 selects binary encoding and bit 1 is the 24-hour flag.
- R2: Reads are combinational from `addr`. Seconds are at 0x0, minutes at 0x2, hours at 0x4, weekday at 0x6, day at 0x7, month at 0x8, year at 0x9, the control byte at 0xA and the mode byte at 0xB. Addresses 0x1, 0x3, 0x5, 0xC, 0xD, 0xE and 0xF always read 0x00.
- R3: A write to a field address is visible on the next read after the clock edge that samples it. A write to any address that always reads 0x00 changes no stored byte.
- R4: A tick with freeze clear adds one second. Seconds wrap from 59 to 0 and carry into minutes, minutes wrap from 59 and carry into hours, and hours wrap from 23 and carry into the day.
- R5: The day wraps to 1 after day 30 in months 4, 6, 9 and 11, and after day 31 in months 1, 3, 5, 7, 8, 10 and 12. It never reaches 0.
- R6: In month 2 the day wraps after 29 when the year is divisible by 4, and after 28 otherwise.
- R7: A day carry out of month 12 sets the month to 1 and advances the year, and year 99 wraps to 00.
- R8: Every day carry advances the weekday, and weekday 7 wraps to 1.
- R9: With the binary bit set to 1, every field is read, stepped and stored as a plain binary number. With it clear, every field is read, stepped and stored as packed BCD.
- R10: While the freeze bit is 1, ticks leave every field unchanged.
- R11: When a write and a tick share a cycle, the addressed byte takes the written value and every other field takes its advanced value.
- R12: Bit 7 of the control byte always reads 0, and bits 6:0 hold the last value written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_sec | input | 1 | One-cycle pulse per elapsed second |
| wr_en | input | 1 | Write strobe for `wdata` at `addr` |
| addr | input | ADDR_W | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |

## Verification
Writes and ticks each take effect at the first rising edge that samples them. Read data follows `addr` through logic only, so a result is due one edge after its stimulus and is visible at once for any address. The bench drives stimulus on the falling edge, lets one rising edge pass, then sets the address and samples a fraction of a nanosecond later, before the next rising edge. Every expected time and date comes from a second count and a month-length formula that the bench evaluates on its own.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int FIELD_W  = 8;
  localparam int N_FIELDS = 7;

  // field slots inside the calendar vector
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_WDAY = 3;
  localparam int F_MDAY = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  // software-visible byte addresses
  localparam int A_SEC  = 'h0;
  localparam int A_MIN  = 'h2;
  localparam int A_HOUR = 'h4;
  localparam int A_WDAY = 'h6;
  localparam int A_MDAY = 'h7;
  localparam int A_MON  = 'h8;
  localparam int A_YEAR = 'h9;
  localparam int A_CTRL = 'hA;
  localparam int A_MODE = 'hB;

  // mode byte bit positions
  localparam int MODE_FREEZE = 7;
  localparam int MODE_BIN    = 2;
  localparam int MODE_H24    = 1;

  localparam logic [7:0] CTRL_RST = 8'h26;
  localparam logic [7:0] MODE_RST = 8'h02;

  // limits of the binary counts
  localparam logic [7:0] SEC_LAST  = 8'd59;
  localparam logic [7:0] MIN_LAST  = 8'd59;
  localparam logic [7:0] HOUR_LAST = 8'd23;
  localparam logic [7:0] WDAY_LAST = 8'd7;
  localparam logic [7:0] MON_LAST  = 8'd12;
  localparam logic [7:0] YEAR_LAST = 8'd99;

  typedef logic [N_FIELDS-1:0][FIELD_W-1:0] cal_t;

  function automatic int field_addr(input int f);
    case (f)
      F_SEC:   return A_SEC;
      F_MIN:   return A_MIN;
      F_HOUR:  return A_HOUR;
      F_WDAY:  return A_WDAY;
      F_MDAY:  return A_MDAY;
      F_MON:   return A_MON;
      default: return A_YEAR;
    endcase
  endfunction

  function automatic logic [7:0] field_reset(input int f);
    case (f)
      F_WDAY:         return 8'h07;
      F_MDAY, F_MON:  return 8'h01;
      default:        return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
    logic [7:0] tens;
    logic [7:0] units;
    tens  = {4'h0, b[7:4]};
    units = {4'h0, b[3:0]};
    return (tens * 8'd10) + units;
  endfunction

  function automatic logic [7:0] bin_to_bcd(input logic [7:0] v);
    logic [7:0] tens;
    logic [7:0] units;
    tens  = v / 8'd10;
    units = v % 8'd10;
    return {tens[3:0], units[3:0]};
  endfunction

  function automatic logic leap_year(input logic [7:0] yr);
    return (yr[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'd2:                    return leap_year(yr) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      default:                 return 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_field_codec.sv
module rtc_field_codec
  import rtc_pkg::*;
#(
  parameter bit TO_BINARY = 1'b1
) (
  input  logic binary_mode,
  input  cal_t fields_in,
  output cal_t fields_out
);

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
    if (TO_BINARY) begin : g_dec
      assign fields_out[i] = binary_mode ? fields_in[i] : bcd_to_bin(fields_in[i]);
    end else begin : g_enc
      assign fields_out[i] = binary_mode ? fields_in[i] : bin_to_bcd(fields_in[i]);
    end
  end

endmodule

// File: rtl/rtc_calendar_step.sv
module rtc_calendar_step
  import rtc_pkg::*;
(
  input  cal_t cur,
  output cal_t nxt,
  output logic sec_wrap,
  output logic min_wrap,
  output logic hour_wrap,
  output logic day_wrap,
  output logic mon_wrap
);

  logic [7:0] dim;

  assign dim       = month_days(cur[F_MON], cur[F_YEAR]);
  assign sec_wrap  = (cur[F_SEC] >= SEC_LAST);
  assign min_wrap  = sec_wrap  && (cur[F_MIN]  >= MIN_LAST);
  assign hour_wrap = min_wrap  && (cur[F_HOUR] >= HOUR_LAST);
  assign day_wrap  = hour_wrap && (cur[F_MDAY] >= dim);
  assign mon_wrap  = day_wrap  && (cur[F_MON]  >= MON_LAST);

  always_comb begin
    nxt = cur;
    nxt[F_SEC] = sec_wrap ? 8'd0 : cur[F_SEC] + 8'd1;
    if (sec_wrap)
      nxt[F_MIN] = min_wrap ? 8'd0 : cur[F_MIN] + 8'd1;
    if (min_wrap)
      nxt[F_HOUR] = hour_wrap ? 8'd0 : cur[F_HOUR] + 8'd1;
    if (hour_wrap) begin
      nxt[F_WDAY] = (cur[F_WDAY] >= WDAY_LAST) ? 8'd1 : cur[F_WDAY] + 8'd1;
      nxt[F_MDAY] = day_wrap ? 8'd1 : cur[F_MDAY] + 8'd1;
    end
    if (day_wrap)
      nxt[F_MON] = mon_wrap ? 8'd1 : cur[F_MON] + 8'd1;
    if (mon_wrap)
      nxt[F_YEAR] = (cur[F_YEAR] >= YEAR_LAST) ? 8'd0 : cur[F_YEAR] + 8'd1;
  end

endmodule

// File: rtl/rtc_read_port.sv
module rtc_read_port
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  cal_t              cal,
  input  logic [7:0]        ctrl,
  input  logic [7:0]        mode,
  output logic [7:0]        rdata
);

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < N_FIELDS; i++)
      if (addr == ADDR_W'(field_addr(i)))
        rdata = cal[i];
    if (addr == ADDR_W'(A_CTRL)) rdata = ctrl;
    if (addr == ADDR_W'(A_MODE)) rdata = mode;
  end

endmodule

// File: rtl/rtc_calendar_regs.sv
module rtc_calendar_regs
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_sec,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  cal_t       cal_q;
  cal_t       cal_bin;
  cal_t       cal_bin_nxt;
  cal_t       cal_enc_nxt;
  logic [7:0] ctrl_q;
  logic [7:0] mode_q;
  logic       advance;
  logic       binary_mode;
  logic       dead_addr;
  logic       sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap;

  assign binary_mode = mode_q[MODE_BIN];
  assign advance     = tick_sec && !mode_q[MODE_FREEZE];

  // addresses that hold nothing and read as zero
  always_comb begin
    dead_addr = 1'b1;
    for (int i = 0; i < N_FIELDS; i++)
      if (addr == ADDR_W'(field_addr(i))) dead_addr = 1'b0;
    if (addr == ADDR_W'(A_CTRL) || addr == ADDR_W'(A_MODE)) dead_addr = 1'b0;
  end

  rtc_field_codec #(.TO_BINARY(1'b1)) u_decode (
    .binary_mode (binary_mode),
    .fields_in   (cal_q),
    .fields_out  (cal_bin)
  );

  rtc_calendar_step u_step (
    .cur       (cal_bin),
    .nxt       (cal_bin_nxt),
    .sec_wrap  (sec_wrap),
    .min_wrap  (min_wrap),
    .hour_wrap (hour_wrap),
    .day_wrap  (day_wrap),
    .mon_wrap  (mon_wrap)
  );

  rtc_field_codec #(.TO_BINARY(1'b0)) u_encode (
    .binary_mode (binary_mode),
    .fields_in   (cal_bin_nxt),
    .fields_out  (cal_enc_nxt)
  );

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_fld
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        q <= field_reset(i);
      else if (wr_en && addr == ADDR_W'(field_addr(i)))
        q <= wdata;
      else if (advance)
        q <= cal_enc_nxt[i];
    end
    assign cal_q[i] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      mode_q <= MODE_RST;
    end else if (wr_en) begin
      if (addr == ADDR_W'(A_CTRL)) ctrl_q <= {1'b0, wdata[6:0]};
      if (addr == ADDR_W'(A_MODE)) mode_q <= wdata;
    end
  end

  rtc_read_port #(.ADDR_W(ADDR_W)) u_read (
    .addr  (addr),
    .cal   (cal_q),
    .ctrl  (ctrl_q),
    .mode  (mode_q),
    .rdata (rdata)
  );

  AST_DEAD_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dead_addr && !advance) |=> $stable(cal_q)); // R3

  AST_SEC_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && sec_wrap && !wr_en) |=> (cal_q[F_SEC] == 8'h00)); // R4

  AST_DAY_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wr_en) |=> (cal_q[F_MDAY] != 8'h00)); // R5

  AST_MONTH_WRAP_TO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && mon_wrap && !wr_en) |=> (cal_q[F_MON] == 8'h01)); // R7

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[MODE_FREEZE] && !wr_en) |=> $stable(cal_q)); // R10

  AST_WRITE_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(A_SEC)) |=> (cal_q[F_SEC] == $past(wdata))); // R11

  AST_CTRL_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(A_CTRL)) |=> (ctrl_q[7] == 1'b0)); // R12

endmodule

// File: tb/sim_rtc_calendar_regs.sv
`timescale 1ns/100ps
module sim_rtc_calendar_regs;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_sec = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rtc_calendar_regs #(.ADDR_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_sec(tick_sec), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [7:0] enc(input int v, input int bin);
    return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    return 30 + ((m + (m > 7 ? 1 : 0)) & 1);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #0.2;
    d = rdata;
  endtask

  task automatic rdchk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_sec = 1'b1;
    @(negedge clk);
    tick_sec = 1'b0;
  endtask

  task automatic load(input logic [7:0] s, mi, h, w, md, mo, y);
    wr(4'h0, s); wr(4'h2, mi); wr(4'h4, h); wr(4'h6, w);
    wr(4'h7, md); wr(4'h8, mo); wr(4'h9, y);
  endtask

  initial begin
    #(150000 * 4);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values, R2 map and zero addresses
    begin
      logic [7:0] exp_rst [16] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h07, 8'h01,
                                   8'h01, 8'h00, 8'h26, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00};
      for (int a = 0; a < 16; a++) rdchk("R1 R2 reset/map", 4'(a), exp_rst[a]);
    end

    // R3 write and read back each field
    load(8'h12, 8'h34, 8'h15, 8'h03, 8'h21, 8'h06, 8'h77);
    rdchk("R3 sec",  4'h0, 8'h12); rdchk("R3 min",  4'h2, 8'h34);
    rdchk("R3 hour", 4'h4, 8'h15); rdchk("R3 wday", 4'h6, 8'h03);
    rdchk("R3 mday", 4'h7, 8'h21); rdchk("R3 mon",  4'h8, 8'h06);
    rdchk("R3 year", 4'h9, 8'h77);
    // R3 writes to dead addresses change nothing
    foreach (exp_dead[i]) ;
    for (int a = 0; a < 16; a++) begin
      if (a == 1 || a == 3 || a == 5 || a >= 12) begin
        wr(4'(a), 8'hA5);
        rdchk("R3 dead read", 4'(a), 8'h00);
      end
    end
    rdchk("R3 sec kept", 4'h0, 8'h12); rdchk("R3 min kept", 4'h2, 8'h34);
    rdchk("R3 hour kept", 4'h4, 8'h15); rdchk("R3 year kept", 4'h9, 8'h77);

    // R12 control byte MSB
    wr(4'hA, 8'hFF);
    rdchk("R12 ctrl", 4'hA, 8'h7F);
    wr(4'hA, 8'h15);
    rdchk("R12 ctrl", 4'hA, 8'h15);

    // R4 long BCD sweep over two hours across midnight
    load(8'h00, 8'h00, 8'h22, 8'h02, 8'h01, 8'h01, 8'h00);
    for (int k = 1; k <= 7205; k++) begin
      int t;
      tick();
      t = 79200 + k;
      rdchk("R4 sec",  4'h0, enc(t % 60, 0));
      rdchk("R4 min",  4'h2, enc((t / 60) % 60, 0));
      rdchk("R4 hour", 4'h4, enc((t / 3600) % 24, 0));
    end
    rdchk("R4 day carry", 4'h7, 8'h02);
    rdchk("R8 wday step", 4'h6, 8'h03);

    // R5 R6 R7 R8 R9 month-end sweep in both encodings
    for (int bin = 0; bin < 2; bin++) begin
      int years [8] = '{0, 1, 2, 48, 49, 50, 96, 99};
      wr(4'hB, bin ? 8'h06 : 8'h02);
      foreach (years[yi]) begin
        for (int m = 1; m <= 12; m++) begin
          for (int ph = 0; ph < 2; ph++) begin
            int y, dm, w, md, em, ey, emd;
            y  = years[yi];
            dm = mdays(m, y);
            w  = ((m + y) % 7) + 1;
            md = ph ? dm : dm - 1;
            load(enc(59, bin), enc(59, bin), enc(23, bin), enc(w, bin),
                 enc(md, bin), enc(m, bin), enc(y, bin));
            tick();
            emd = ph ? 1 : dm;
            em  = (ph && m == 12) ? 1 : (ph ? m + 1 : m);
            ey  = (ph && m == 12) ? (y + 1) % 100 : y;
            rdchk("R9 sec",        4'h0, enc(0, bin));
            rdchk("R4 hour wrap",  4'h4, enc(0, bin));
            rdchk(m == 2 ? "R6 feb day" : "R5 day", 4'h7, enc(emd, bin));
            rdchk("R7 month",      4'h8, enc(em, bin));
            rdchk("R7 year",       4'h9, enc(ey, bin));
            rdchk("R8 weekday",    4'h6, enc((w % 7) + 1, bin));
          end
        end
      end
    end

    // R9 binary minute carry
    load(8'd59, 8'd10, 8'd5, 8'd1, 8'd3, 8'd3, 8'd20);
    tick();
    rdchk("R9 bin sec", 4'h0, 8'd0);
    rdchk("R9 bin min", 4'h2, 8'd11);
    wr(4'hB, 8'h02);

    // R10 freeze
    load(8'h30, 8'h45, 8'h10, 8'h04, 8'h15, 8'h05, 8'h21);
    wr(4'hB, 8'h82);
    rdchk("R10 mode", 4'hB, 8'h82);
    for (int k = 0; k < 5; k++) tick();
    rdchk("R10 sec frozen", 4'h0, 8'h30);
    rdchk("R10 min frozen", 4'h2, 8'h45);
    wr(4'hB, 8'h02);
    tick();
    rdchk("R10 released", 4'h0, 8'h31);

    // R11 write and tick in the same cycle
    load(8'h59, 8'h10, 8'h08, 8'h04, 8'h15, 8'h05, 8'h21);
    @(negedge clk);
    wr_en = 1'b1; tick_sec = 1'b1; addr = 4'h0; wdata = 8'h30;
    @(negedge clk);
    wr_en = 1'b0; tick_sec = 1'b0;
    rdchk("R11 written byte", 4'h0, 8'h30);
    rdchk("R11 others advance", 4'h2, 8'h11);
    rdchk("R11 hour kept", 4'h4, 8'h08);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  int exp_dead [1];

endmodule